// File: doc/BRIEF.md
# Interrupt Priority Claim Engine

This block is the arbitration core of a platform interrupt controller. It watches a set of level-sensitive interrupt sources and keeps a pending bit and a claimed bit for each. Each source has a 3-bit priority. Each target context has its own enable mask and its own threshold. For every context the block drives one interrupt line. That line is high whenever the context has at least one source that is pending, enabled and not claimed, and whose priority is strictly above the context's threshold.

A context's handler claims an interrupt by pulsing `claim_req` with its context index. In the same cycle the block returns the ID of the winning source on `claim_id`. The winner is the highest priority, and a tie goes to the lowest ID. On the next clock edge the winner's pending bit is cleared and its claimed bit is set. When the handler is done it pulses `cmpl_req` with the source ID, and that releases the source. Source 0 is reserved. A claim result of 0 means that nothing is available.

Top module: `irq_claim_engine`

## Requirements
- R1: A source is a candidate for context c only when its pending bit is 1, its claimed bit is 0 and bit s of that context's enable mask (written whole through `en_mask`, bit s = source s) is 1.
- R2: A candidate qualifies only when its priority is strictly greater than the context threshold. A priority equal to the threshold never qualifies.
- R3: Among qualifying candidates the highest priority wins. Between equal priorities the lowest source ID wins.
- R4: Source 0 is reserved. Its pending and claimed bits stay 0, it never wins, and `claim_id` is 0 whenever `claim_req` is low or no source qualifies.
- R5: While `claim_req` is high, `claim_id` shows the winner for `claim_ctx` in the same cycle. At the following edge that source's pending bit is 0 and its claimed bit is 1.
- R6: A complete request clears the claimed bit of source `cmpl_id` (6 bits wide) only when `cmpl_id` is below NUM_SRC. Larger IDs have no effect.
- R7: `ctx_irq[c]` is high exactly when context c has a qualifying candidate. It reflects a register write, a complete or a level change from the clock edge that captures it.
- R8: Each pending bit is loaded from its source level every cycle, except in the claim cycle of that source. A source whose level is still high is therefore pending again once it has been completed.
- R9: Priorities are 3 bits wide (0 to 7). A source with priority 0 never qualifies, whatever the threshold.
- R10: Reset clears all pending bits, claimed bits, enable masks, priorities and thresholds to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Source interrupt levels, bit s = source s |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | ID_W | Source whose priority is written |
| prio_val | input | 3 | Priority value |
| en_we | input | 1 | Enable mask write strobe |
| en_ctx | input | CTX_W | Context whose enable mask is written |
| en_mask | input | NUM_SRC | New enable mask |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context whose threshold is written |
| thr_val | input | 3 | Threshold value |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Claiming context |
| claim_id | output | ID_W | Claimed source ID, 0 when none |
| cmpl_req | input | 1 | Complete strobe |
| cmpl_id | input | ID_W+1 | Source ID being completed |
| ctx_irq | output | NUM_CTX | Per-context interrupt line |

## Verification
The assertions assume a few things about the inputs. Context indices are always below NUM_CTX. `src_level` does not change in the cycle of a claim. All source levels are held at 0 while reset is applied. The bench keeps to all of this. It drives levels and register writes only in cycles where no claim strobe is raised, it uses only contexts 0 and 1, and it keeps every level low until reset has been released. Out-of-range complete IDs are still sent, because the block must tolerate them.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/ctx_arbiter.sv
module ctx_arbiter
    import irq_claim_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int ID_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             cand_mask,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  prio_t                          thr,
    output logic [ID_W-1:0]                win_id,
    output logic                           win_vld
);
    localparam int LEAVES = 1 << ID_W;

    typedef struct packed {
        logic            vld;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } node_t;

    // Right child carries the higher IDs, so it replaces the left one only
    // on a strictly greater priority: ties keep the lower ID.
    function automatic node_t better(node_t lo, node_t hi);
        if (hi.vld && (!lo.vld || hi.prio > lo.prio)) return hi;
        return lo;
    endfunction

    node_t node [1:2*LEAVES-1];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < NUM_SRC) begin : g_real
            assign node[LEAVES+l] = '{vld:  cand_mask[l] && (prio[l] > thr),
                                      prio: prio[l],
                                      id:   ID_W'(l)};
        end else begin : g_pad
            assign node[LEAVES+l] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        assign node[k] = better(node[2*k], node[2*k+1]);
    end

    assign win_vld = node[1].vld;
    assign win_id  = node[1].vld ? node[1].id : '0;
endmodule

// File: rtl/irq_claim_engine.sv
module irq_claim_engine
    import irq_claim_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    localparam int ID_W  = $clog2(NUM_SRC),
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               prio_we,
    input  logic [ID_W-1:0]    prio_sel,
    input  logic [PRIO_W-1:0]  prio_val,
    input  logic               en_we,
    input  logic [CTX_W-1:0]   en_ctx,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic               thr_we,
    input  logic [CTX_W-1:0]   thr_ctx,
    input  logic [PRIO_W-1:0]  thr_val,
    input  logic               claim_req,
    input  logic [CTX_W-1:0]   claim_ctx,
    output logic [ID_W-1:0]    claim_id,
    input  logic               cmpl_req,
    input  logic [ID_W:0]      cmpl_id,
    output logic [NUM_CTX-1:0] ctx_irq
);
    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
        logic [NUM_SRC-1:0]              pend;
        logic [NUM_SRC-1:0]              clm;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CTX-1:0][ID_W-1:0] win_id;
    logic [NUM_CTX-1:0]           win_vld;
    logic                         claim_hit;
    logic [NUM_SRC-1:0]           pend_vec, clm_vec;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        ctx_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
            .cand_mask (st_q.pend & ~st_q.clm & st_q.en[c]),
            .prio      (st_q.prio),
            .thr       (st_q.thr[c]),
            .win_id    (win_id[c]),
            .win_vld   (win_vld[c])
        );
    end

    assign ctx_irq   = win_vld;
    assign claim_hit = claim_req && (int'(claim_ctx) < NUM_CTX) && win_vld[claim_ctx];
    assign claim_id  = claim_hit ? win_id[claim_ctx] : '0;
    assign pend_vec  = st_q.pend;
    assign clm_vec   = st_q.clm;

    always_comb begin
        st_d = st_q;
        if (prio_we) begin
            st_d.prio[prio_sel] = (prio_sel == '0) ? '0 : prio_val;
        end
        if (en_we && int'(en_ctx) < NUM_CTX) begin
            st_d.en[en_ctx] = en_mask;
        end
        if (thr_we && int'(thr_ctx) < NUM_CTX) begin
            st_d.thr[thr_ctx] = thr_val;
        end
        st_d.pend    = src_level;
        st_d.pend[0] = 1'b0;
        if (cmpl_req && cmpl_id < (ID_W+1)'(NUM_SRC)) begin
            st_d.clm[cmpl_id[ID_W-1:0]] = 1'b0;
        end
        if (claim_hit) begin
            st_d.pend[claim_id] = 1'b0;
            st_d.clm[claim_id]  = 1'b1;
        end
        st_d.clm[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_claim_engine_chk.sv
module irq_claim_engine_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    localparam int ID_W  = $clog2(NUM_SRC),
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_level,
    input logic               claim_req,
    input logic [CTX_W-1:0]   claim_ctx,
    input logic [ID_W-1:0]    claim_id,
    input logic               cmpl_req,
    input logic [ID_W:0]      cmpl_id,
    input logic [NUM_CTX-1:0] ctx_irq,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [NUM_SRC-1:0] clm_vec
);
    AST_CAND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req && claim_id != '0) |-> (pend_vec[claim_id] && !clm_vec[claim_id])); // R1

    AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_vec[0] && !clm_vec[0])); // R4

    AST_NO_CLAIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_req |-> (claim_id == '0)); // R4

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req && claim_id != '0) |=> (clm_vec[$past(claim_id)] && !pend_vec[$past(claim_id)])); // R5

    AST_BAD_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_req && cmpl_id >= (ID_W+1)'(NUM_SRC) && !claim_req) |=> (clm_vec == $past(clm_vec))); // R6

    AST_IRQ_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        claim_req |-> ((claim_id != '0) == ctx_irq[claim_ctx])); // R7

    AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_req |=> (pend_vec[NUM_SRC-1:1] == $past(src_level[NUM_SRC-1:1]))); // R8
endmodule

bind irq_claim_engine irq_claim_engine_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_level (src_level),
    .claim_req (claim_req),
    .claim_ctx (claim_ctx),
    .claim_id  (claim_id),
    .cmpl_req  (cmpl_req),
    .cmpl_id   (cmpl_id),
    .ctx_irq   (ctx_irq),
    .pend_vec  (pend_vec),
    .clm_vec   (clm_vec)
);

// File: tb/irq_claim_engine_tb_top.sv
`timescale 1ns/100ps
module irq_claim_engine_tb_top;
    localparam int NS = 32;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_level = '0;
    logic        prio_we = 1'b0;
    logic [4:0]  prio_sel = '0;
    logic [2:0]  prio_val = '0;
    logic        en_we = 1'b0;
    logic        en_ctx = 1'b0;
    logic [31:0] en_mask = '0;
    logic        thr_we = 1'b0;
    logic        thr_ctx = 1'b0;
    logic [2:0]  thr_val = '0;
    logic        claim_req = 1'b0;
    logic        claim_ctx = 1'b0;
    logic [4:0]  claim_id;
    logic        cmpl_req = 1'b0;
    logic [5:0]  cmpl_id = '0;
    logic [1:0]  ctx_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    irq_claim_engine #(.NUM_SRC(NS), .NUM_CTX(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .prio_we(prio_we), .prio_sel(prio_sel), .prio_val(prio_val),
        .en_we(en_we), .en_ctx(en_ctx), .en_mask(en_mask),
        .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
        .claim_req(claim_req), .claim_ctx(claim_ctx), .claim_id(claim_id),
        .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .ctx_irq(ctx_irq)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares the combinational claim result mid-cycle
    always @(negedge clk) begin
        if (claim_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard", int'(claim_id), -1);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(int'(claim_id) == e, t, int'(claim_id), e);
            end
        end
    end

    task automatic claim(input bit c, input int exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        claim_ctx = c;
        claim_req = 1'b1;
        @(posedge clk); #1;
        claim_req = 1'b0;
    endtask

    task automatic complete(input int id);
        @(posedge clk); #1;
        cmpl_id  = 6'(id);
        cmpl_req = 1'b1;
        @(posedge clk); #1;
        cmpl_req = 1'b0;
    endtask

    task automatic set_prio(input int s, input int v);
        @(posedge clk); #1;
        prio_sel = 5'(s); prio_val = 3'(v); prio_we = 1'b1;
        @(posedge clk); #1;
        prio_we = 1'b0;
    endtask

    task automatic set_en(input bit c, input logic [31:0] m);
        @(posedge clk); #1;
        en_ctx = c; en_mask = m; en_we = 1'b1;
        @(posedge clk); #1;
        en_we = 1'b0;
    endtask

    task automatic set_thr(input bit c, input int v);
        @(posedge clk); #1;
        thr_ctx = c; thr_val = 3'(v); thr_we = 1'b1;
        @(posedge clk); #1;
        thr_we = 1'b0;
    endtask

    task automatic set_lvl(input logic [31:0] l);
        @(posedge clk); #1;
        src_level = l;
        @(posedge clk); #1;
    endtask

    task automatic check_irq(input logic [1:0] exp, input string tag);
        @(negedge clk);
        chk(ctx_irq == exp, tag, int'(ctx_irq), int'(exp));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        check_irq(2'b00, "R10 reset irq");
        claim(1'b0, 0, "R10 reset claim");

        set_prio(3, 5);
        set_prio(7, 5);
        set_prio(9, 2);
        set_en(1'b0, 32'h0000_0288);
        set_lvl(32'h0000_0288);
        check_irq(2'b01, "R7 irq on pending");

        claim(1'b0, 3, "R3 tie lowest id");
        claim(1'b0, 7, "R3 next equal prio");
        claim(1'b0, 9, "R5 lower prio last");
        claim(1'b0, 0, "R5 all claimed");
        check_irq(2'b00, "R7 irq drops");

        complete(40);
        claim(1'b0, 0, "R6 out-of-range complete ignored");

        complete(7);
        claim(1'b0, 7, "R8 re-pend after complete");

        set_lvl(32'h0000_0208);
        complete(7);
        claim(1'b0, 0, "R8 level low not pending");

        complete(3);
        complete(9);
        set_thr(1'b0, 5);
        check_irq(2'b00, "R2 equal to threshold");
        claim(1'b0, 0, "R2 equal to threshold");
        set_thr(1'b0, 4);
        claim(1'b0, 3, "R2 above threshold");
        claim(1'b0, 0, "R2 below threshold");

        set_en(1'b1, 32'h0000_0200);
        set_thr(1'b1, 1);
        check_irq(2'b10, "R1 enable per context");
        claim(1'b1, 9, "R1 context 1 claim");
        check_irq(2'b00, "R1 after context 1 claim");

        set_thr(1'b0, 0);
        set_en(1'b0, 32'h0000_1289);
        set_lvl(32'h0000_1209);
        set_prio(0, 7);
        claim(1'b0, 0, "R9 priority zero and R4 source zero");
        check_irq(2'b00, "R4 no irq from source zero");

        set_prio(12, 7);
        complete(3);
        claim(1'b0, 12, "R3 higher priority beats lower id");
        claim(1'b0, 3, "R3 remaining source");

        set_prio(31, 7);
        set_en(1'b0, 32'h8000_1289);
        set_lvl(32'h8000_1209);
        complete(12);
        claim(1'b0, 12, "R3 tie at top priority");
        claim(1'b0, 31, "R9 top source id");
        claim(1'b0, 0, "R5 empty again");

        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule